// File: doc/BRIEF.md
# Multi-Channel Sample/Convert Sequencer

This block is the digital controller that steps up to four sample/hold channels through one acquisition and conversion pass while they share a single converter. A start trigger begins a pass. The block opens a tracking window for one or more channels, each window lasting a fixed number of clock cycles. It then raises a conversion request for each channel in turn and waits on every request until the converter returns a done strobe. When the last channel has been converted, a one-cycle completion pulse follows.

Three configuration inputs set the pass. A two-bit width code sets how many channels take part. A simultaneous flag puts every participating channel into one shared tracking window, so that conversion is the only serial part. A high-resolution flag reduces the pass to channel 0 alone. The block copies these inputs only while it is disabled. Changes made while it is enabled cannot disturb a pass in progress. Dropping the enable aborts any pass at once.

Top module: `scs_top`

## Requirements
- R1: The width code sets the channel count: 2'b00 gives channel 0 alone, 2'b01 gives channels 0 and 1, and 2'b10 or 2'b11 gives channels 0 to 3.
- R2: With the simultaneous flag clear, each channel in turn tracks alone (only its own track_en bit high) for SAMPLE_CYCLES cycles and is then converted, in ascending order from channel 0.
- R3: With the simultaneous flag set and more than one channel taking part, all participating track_en bits are high together for one window of SAMPLE_CYCLES cycles, and the channels are then converted back to back in ascending order without further tracking.
- R4: With only channel 0 taking part, the simultaneous flag changes nothing.
- R5: With the high-resolution flag set, the pass uses channel 0 alone, whatever the width code and the simultaneous flag say.
- R6: conv_req stays high, with conv_idx naming the channel, from the end of that channel's tracking until the cycle in which conv_done is seen. No track_en bit is high while conv_req is high. A conv_done strobe that arrives while no conversion is requested is ignored.
- R7: seq_done is high for exactly one cycle, the cycle right after the conv_done of the last channel. It occurs once per pass.
- R8: A start trigger that arrives while a pass is running is ignored.
- R9: While enable is low, the block is idle and track_en, conv_req, conv_idx and seq_done are all zero. Dropping enable aborts a running pass, and no seq_done follows.
- R10: The configuration inputs are copied only on clock edges at which enable is low. Changes made while enable is high do not affect the channel count, the order or the tracking pattern.
- R11: After reset, all outputs are zero and the held configuration is one channel, simultaneous flag clear, high-resolution flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable; low aborts and idles |
| cfg_width | input | 2 | Channel-count code |
| cfg_simul | input | 1 | Simultaneous tracking flag |
| cfg_hires | input | 1 | High-resolution (single channel) flag |
| start | input | 1 | Start trigger for one pass |
| conv_done | input | 1 | Converter done strobe |
| track_en | output | NUM_CH | Per-channel track (sample) enables |
| conv_req | output | 1 | Conversion request |
| conv_idx | output | IDX_W | Channel being converted |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default four channels and shortens the tracking window to SAMPLE_CYCLES = 3. A fixed-latency converter stub therefore completes each pass in a few tens of cycles, and every width code, flag combination, abort and mid-pass disturbance fits in one short run. With four channels the full sequential pass is reachable, so it checks both the widest one-hot tracking walk and the widest shared window. It also reaches the 2'b11 alias of the four-channel code.

// File: rtl/scs_pkg.sv
// Shared types and helpers for the sample/convert sequencer.
// Assumes at most a handful of channels; index width is derived by users.
package scs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRACK = 2'd1,
        PH_CONV  = 2'd2
    } scs_phase_t;

endpackage

// File: rtl/scs_cfg_hold.sv
// Holds the configuration while the block is enabled and derives the
// effective last channel index and simultaneous mode from it.
// Assumes NUM_CH >= 2; code 1x maps to the full channel set.
module scs_cfg_hold #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       cfg_width,
    input  logic             cfg_simul,
    input  logic             cfg_hires,
    output logic [IDX_W-1:0] last_idx,
    output logic             simul_eff
);

    logic [1:0] width_q;
    logic       simul_q;
    logic       hires_q;

    // Copy configuration only on edges where the module is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= 2'b00;
            simul_q <= 1'b0;
            hires_q <= 1'b0;
        end else if (!enable) begin
            width_q <= cfg_width;
            simul_q <= cfg_simul;
            hires_q <= cfg_hires;
        end
    end

    // Decode the held code into the index of the final channel.
    always_comb begin
        if (hires_q || width_q == 2'b00)
            last_idx = '0;
        else if (width_q == 2'b01)
            last_idx = IDX_W'(1);
        else
            last_idx = IDX_W'(NUM_CH - 1);
    end

    // Simultaneous tracking only matters with more than one channel.
    assign simul_eff = simul_q && !hires_q && (last_idx != '0);

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> $stable({width_q, simul_q, hires_q})); // R10

endmodule

// File: rtl/scs_timer.sv
// Counts the tracking window; raises expire in its final cycle.
// Assumes run stays high for the whole window; clears when run is low.
module scs_timer #(
    parameter int SAMPLE_CYCLES = 4,
    localparam int TW = $clog2(SAMPLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    logic [TW-1:0] cnt_q;

    assign expire = run && (cnt_q == TW'(SAMPLE_CYCLES - 1));

    // Advance while running, restart at expiry or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/scs_ctrl.sv
// Phase controller: idle, tracking, converting; walks channel index
// upward and emits the completion pulse after the last conversion.
// Assumes configuration inputs are stable while enabled.
module scs_ctrl
    import scs_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             conv_done,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             simul_eff,
    input  logic             tmr_expire,
    output scs_phase_t       phase,
    output logic [IDX_W-1:0] cur_idx,
    output logic             seq_done
);

    // Phase, channel index and completion pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cur_idx  <= '0;
            seq_done <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            if (!enable) begin
                phase   <= PH_IDLE;
                cur_idx <= '0;
            end else begin
                unique case (phase)
                    PH_IDLE: begin
                        if (start) begin
                            phase   <= PH_TRACK;
                            cur_idx <= '0;
                        end
                    end
                    PH_TRACK: begin
                        if (tmr_expire)
                            phase <= PH_CONV;
                    end
                    PH_CONV: begin
                        if (conv_done) begin
                            if (cur_idx == last_idx) begin
                                phase    <= PH_IDLE;
                                cur_idx  <= '0;
                                seq_done <= 1'b1;
                            end else begin
                                cur_idx <= cur_idx + 1'b1;
                                phase   <= simul_eff ? PH_CONV : PH_TRACK;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done); // R7
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase == PH_IDLE && !seq_done)); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_CONV && !conv_done) |=> phase == PH_CONV); // R8

endmodule

// File: rtl/scs_out.sv
// Output decode: track enables, conversion request and index from phase.
// Assumes cur_idx never exceeds last_idx while converting.
module scs_out
    import scs_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scs_phase_t        phase,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              simul_eff,
    output logic [NUM_CH-1:0] track_en,
    output logic              conv_req,
    output logic [IDX_W-1:0]  conv_idx
);

    // One track enable per channel: shared window or the current channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_track
        assign track_en[g] = (phase == PH_TRACK) &&
                             (simul_eff ? (IDX_W'(g) <= last_idx)
                                        : (IDX_W'(g) == cur_idx));
    end

    // Request and index are valid only while converting.
    assign conv_req = (phase == PH_CONV);
    assign conv_idx = conv_req ? cur_idx : '0;

    AST_SEQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !simul_eff |-> $onehot0(track_en)); // R2
    AST_NO_TRACK_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (track_en == '0)); // R6
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_idx <= last_idx)); // R1

endmodule

// File: rtl/scs_top.sv
// Top of the sample/convert sequencer: config hold, window timer,
// phase controller and output decode. Converter is external.
module scs_top #(
    parameter int NUM_CH        = 4,
    parameter int SAMPLE_CYCLES = 4,
    localparam int IDX_W        = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_simul,
    input  logic              cfg_hires,
    input  logic              start,
    input  logic              conv_done,
    output logic [NUM_CH-1:0] track_en,
    output logic              conv_req,
    output logic [IDX_W-1:0]  conv_idx,
    output logic              seq_done
);
    import scs_pkg::*;

    logic [IDX_W-1:0] last_idx;
    logic             simul_eff;
    logic             tmr_expire;
    scs_phase_t       phase;
    logic [IDX_W-1:0] cur_idx;

    scs_cfg_hold #(.NUM_CH(NUM_CH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_width(cfg_width), .cfg_simul(cfg_simul), .cfg_hires(cfg_hires),
        .last_idx(last_idx), .simul_eff(simul_eff)
    );

    scs_timer #(.SAMPLE_CYCLES(SAMPLE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(phase == PH_TRACK), .expire(tmr_expire)
    );

    scs_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .conv_done(conv_done), .last_idx(last_idx), .simul_eff(simul_eff),
        .tmr_expire(tmr_expire), .phase(phase), .cur_idx(cur_idx),
        .seq_done(seq_done)
    );

    scs_out #(.NUM_CH(NUM_CH)) u_out (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cur_idx(cur_idx),
        .last_idx(last_idx), .simul_eff(simul_eff),
        .track_en(track_en), .conv_req(conv_req), .conv_idx(conv_idx)
    );

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> $past(conv_req && conv_done)); // R7

endmodule

// File: tb/scs_top_tb.sv
module scs_top_tb;
    localparam int NCH  = 4;
    localparam int SAMP = 3;
    localparam int LAT  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [1:0] cfg_width = 2'b00;
    logic cfg_simul = 1'b0;
    logic cfg_hires = 1'b0;
    logic start = 1'b0;
    logic conv_done = 1'b0;
    logic [NCH-1:0] track_en;
    logic conv_req;
    logic [1:0] conv_idx;
    logic seq_done;

    scs_top #(.NUM_CH(NCH), .SAMPLE_CYCLES(SAMP)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_width(cfg_width),
        .cfg_simul(cfg_simul), .cfg_hires(cfg_hires), .start(start),
        .conv_done(conv_done), .track_en(track_en), .conv_req(conv_req),
        .conv_idx(conv_idx), .seq_done(seq_done)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R11";

    // behavioural reference state
    int m_phase = 0, m_ch = 0, m_tmr = 0, m_done = 0;
    int m_w = 0, m_sim = 0, m_hi = 0;

    // recorders
    int order[$];
    int done_cnt = 0;
    int max_pop = 0;
    int stub_cnt = 0;
    bit spur_mode = 0;

    function automatic int chans(int w, int hi);
        if (hi != 0 || w == 0) return 1;
        if (w == 1) return 2;
        return NCH;
    endfunction

    task automatic check(string t, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // reference model advances on each rising edge
    always @(posedge clk) begin
        int n, se;
        n  = chans(m_w, m_hi);
        se = (m_sim != 0 && n > 1) ? 1 : 0;
        if (!rst_n) begin
            m_phase = 0; m_ch = 0; m_tmr = 0; m_done = 0;
            m_w = 0; m_sim = 0; m_hi = 0;
        end else begin
            m_done = 0;
            if (!enable) begin
                m_phase = 0; m_ch = 0; m_tmr = 0;
            end else if (m_phase == 0) begin
                if (start) begin m_phase = 1; m_ch = 0; m_tmr = 0; end
            end else if (m_phase == 1) begin
                m_tmr++;
                if (m_tmr == SAMP) begin m_phase = 2; m_tmr = 0; end
            end else if (conv_done) begin
                if (m_ch == n - 1) begin m_phase = 0; m_ch = 0; m_done = 1; end
                else begin m_ch++; m_phase = se ? 2 : 1; end
            end
            if (!enable) begin
                m_w = int'(cfg_width); m_sim = int'(cfg_simul); m_hi = int'(cfg_hires);
            end
        end
    end

    // compare every cycle, then run converter stub and recorders
    always @(negedge clk) begin
        int n, se, e_track, e_req, e_idx;
        cycles++;
        n  = chans(m_w, m_hi);
        se = (m_sim != 0 && n > 1) ? 1 : 0;
        e_track = 0;
        if (m_phase == 1) e_track = se ? ((1 << n) - 1) : (1 << m_ch);
        e_req = (m_phase == 2) ? 1 : 0;
        e_idx = e_req ? m_ch : 0;
        check(tag, int'(track_en), e_track, "track_en");
        check(tag, int'(conv_req), e_req, "conv_req");
        check(tag, int'(conv_idx), e_idx, "conv_idx");
        check(tag, int'(seq_done), m_done, "seq_done");
        if (seq_done) done_cnt++;
        if ($countones(track_en) > max_pop) max_pop = $countones(track_en);
        if (conv_done) begin
            conv_done = 1'b0;
            stub_cnt = 0;
        end else if (conv_req) begin
            stub_cnt++;
            if (stub_cnt == LAT) begin
                conv_done = 1'b1;
                order.push_back(int'(conv_idx));
            end
        end else if (spur_mode && track_en != '0) begin
            conv_done = 1'b1; // R6: stray strobe while tracking
        end
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // mode: 0 plain, 1 stray done, 2 restart mid-pass, 3 config change mid-pass
    task automatic run_pass(int w, int sim, int hi, string t, int mode);
        int n, epop;
        n = chans(w, hi);
        epop = (sim != 0 && n > 1) ? n : 1;
        @(negedge clk);
        tag = t;
        enable = 1'b0;
        cfg_width = 2'(w); cfg_simul = 1'(sim); cfg_hires = 1'(hi);
        spur_mode = (mode == 1);
        @(negedge clk);
        order.delete(); done_cnt = 0; max_pop = 0;
        enable = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        if (mode == 2) begin start = 1'b1; @(negedge clk); start = 1'b0; end
        if (mode == 3) begin cfg_width = 2'b00; cfg_hires = 1'b1; cfg_simul = 1'b1; end
        for (int i = 0; i < 300 && done_cnt == 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        check(t, order.size(), n, "conversion count");
        for (int i = 0; i < order.size(); i++) check(t, order[i], i, "conversion order");
        check(t, done_cnt, 1, "seq_done pulses");
        check(t, max_pop, epop, "channels tracked together");
        spur_mode = 0;
        enable = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R11";
        check("R11", int'(track_en), 0, "reset track_en");
        check("R11", int'({conv_req, seq_done}), 0, "reset req/done");
        rst_n = 1'b1;
        @(negedge clk);
        // R11: held config after reset is one channel; pass with enable only
        enable = 1'b1; start = 1'b1; @(negedge clk); start = 1'b0;
        order.delete(); done_cnt = 0;
        repeat (20) @(negedge clk);
        check("R11", order.size(), 1, "post-reset channel count");
        enable = 1'b0;

        run_pass(0, 0, 0, "R1", 0);
        run_pass(1, 0, 0, "R2", 0);
        run_pass(2, 0, 0, "R2", 0);
        run_pass(3, 0, 0, "R1", 0);
        run_pass(1, 1, 0, "R3", 0);
        run_pass(2, 1, 0, "R3", 0);
        run_pass(0, 1, 0, "R4", 0);
        run_pass(3, 1, 1, "R5", 0);
        run_pass(2, 0, 1, "R5", 0);
        run_pass(2, 0, 0, "R6", 1);
        run_pass(2, 1, 0, "R7", 0);
        run_pass(2, 0, 0, "R8", 2);
        run_pass(2, 0, 0, "R10", 3);

        // R9: abort mid-pass
        @(negedge clk);
        tag = "R9";
        cfg_width = 2'b10; cfg_simul = 1'b0; cfg_hires = 1'b0;
        @(negedge clk);
        done_cnt = 0;
        enable = 1'b1; start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R9", int'(track_en), 0, "track_en after abort");
        check("R9", int'(conv_req), 0, "conv_req after abort");
        repeat (30) @(negedge clk);
        check("R9", done_cnt, 0, "seq_done after abort");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule